// File: doc/BRIEF.md
# Program-Cycle Status Reporter

This block sits on the read path of a byte-lane-organised non-volatile memory and tells a host whether an internal program cycle is still under way. While a load or program cycle is active, every read of the 32-bit data bus is answered with status instead of array contents. In each byte lane the top bit is a polling bit: the complement of the top bit of the byte last written into that lane. The next bit down is a toggle bit that changes on every completed read. The six low bits echo the byte last loaded into the lane. Once the cycle ends, reads pass the array word through unchanged.

The block also drives the enable of an open-drain ready/busy pin. It pulls the line low from the first write strobe of a load until the program cycle finishes. It never drives the line high, so several devices can share one wired-OR line. A low-active reset pin blocks reads, floats the bus, releases the busy line and returns the controller to its ready state.

The controller has three states. `ST_READY` is idle, with no status shown. `ST_LOAD` begins at the first write strobe: bytes are still being loaded and the program engine has not yet reported busy. `ST_PROG` means the program engine reports busy. The transitions are:
- load-start: `ST_READY` to `ST_LOAD` on a write strobe. This also resets the toggle bit to 1.
- engine-start: `ST_LOAD` to `ST_PROG` when the busy flag is high.
- engine-done: `ST_PROG` to `ST_READY` when the busy flag is low.
- pin-abort: any state to `ST_READY` while the reset pin is low.

Top module: `prog_status_rpt`

## Requirements
- R1: In `ST_READY`, an enabled read returns `array_data_i` unchanged on `rd_data_o`.
- R2: `rd_oe_o` is 1 exactly when `ce_n_i`, `oe_n_i` and `res_n_i` are 0, 0 and 1 and `we_n_i` is 1. When `rd_oe_o` is 0, `rd_data_o` is all zeros.
- R3: A `wr_stb_i` pulse in `ST_READY` with `res_n_i` high sets `rdy_pull_o` to 1 on the next clock. `rdy_pull_o` stays 1 while the state is `ST_LOAD` or `ST_PROG`. `rdy_pull_o` is a pull-low enable only.
- R4: With `busy_i` high in `ST_LOAD`, the state moves to `ST_PROG`. With `busy_i` low in `ST_PROG`, `rdy_pull_o` returns to 0 on the next clock.
- R5: In `ST_LOAD` and `ST_PROG`, an enabled read returns the following in lane k (bits 8k+7..8k). Bit 8k+7 is the inverse of bit 7 of the last byte stored in lane k. Bits 8k+5..8k are bits 5..0 of that byte. A lane stores `wr_data_i[8k+7:8k]` on a `wr_stb_i` with `wr_be_i[k]` high, in `ST_READY` or `ST_LOAD` only. Reset clears all stored bytes to 0.
- R6: In `ST_LOAD` and `ST_PROG`, bit 8k+6 of every lane is the toggle bit. It reads 1 on the first read after load-start. It inverts once per completed read, where completion is the clock on which the read-enable condition of R2 goes from true to false. Holding a read open over many clocks leaves it unchanged.
- R7: After engine-done, reads return array data again. The next load-start restarts the toggle bit at 1.
- R8: While `res_n_i` is 0, `rd_oe_o` is 0 and `rd_data_o` is 0. On the next clock `rdy_pull_o` is 0. `wr_stb_i` has no effect, so `rdy_pull_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| res_n_i | input | 1 | Reset/protect pin, active low |
| busy_i | input | 1 | Program engine running |
| wr_stb_i | input | 1 | One-clock write strobe for a loaded word |
| wr_be_i | input | 4 | Byte lanes written by the strobe |
| wr_data_i | input | 32 | Word being loaded |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| array_data_i | input | 32 | Array word at the read address |
| rd_data_o | output | 32 | Read data bus |
| rd_oe_o | output | 1 | Read bus drive enable |
| rdy_pull_o | output | 1 | Pull ready/busy line low |

## Verification
The assertions take for granted that `wr_stb_i` and the pin inputs are synchronous to `clk` and stable between edges. They also assume `busy_i` only rises after a load has begun. The toggle check relies on every completed read being visible as a read-enable level lasting at least one clock. The stimulus changes all inputs only on the falling edge. It raises `busy_i` only while the reference model is in its load state and lowers it only while the model is in its program state. It holds each read-enable level for at least one full clock.

// File: rtl/psr_pkg.sv
package psr_pkg;
    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_LOAD  = 2'd1,
        ST_PROG  = 2'd2
    } psr_state_e;
endpackage

// File: rtl/psr_read_detect.sv
module psr_read_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic res_n_i,
    input  logic ce_n_i,
    input  logic oe_n_i,
    input  logic we_n_i,
    output logic rd_act_o,
    output logic rd_done_o
);
    logic rd_prev_q;

    assign rd_act_o = ~ce_n_i & ~oe_n_i & we_n_i & res_n_i;

    always_ff @(posedge clk) begin
        if (!rst_n) rd_prev_q <= 1'b0;
        else        rd_prev_q <= rd_act_o;
    end

    assign rd_done_o = rd_prev_q & ~rd_act_o;
endmodule

// File: rtl/psr_ctrl_fsm.sv
module psr_ctrl_fsm
    import psr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic res_n_i,
    input  logic busy_i,
    input  logic wr_stb_i,
    input  logic rd_done_i,
    output logic status_o,
    output logic tgl_o,
    output logic pull_o,
    output logic ld_ok_o
);
    psr_state_e state_q, state_d;
    logic tgl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!res_n_i) begin
            state_d = ST_READY;
        end else begin
            unique case (state_q)
                ST_READY: if (wr_stb_i) state_d = ST_LOAD;
                ST_LOAD:  if (busy_i)   state_d = ST_PROG;
                ST_PROG:  if (!busy_i)  state_d = ST_READY;
                default:                state_d = ST_READY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            tgl_q <= 1'b1;
        else if (res_n_i && state_q == ST_READY && wr_stb_i)
            tgl_q <= 1'b1;
        else if (state_q != ST_READY && rd_done_i)
            tgl_q <= ~tgl_q;
    end

    always_comb begin
        status_o = (state_q != ST_READY);
        pull_o   = (state_q != ST_READY);
        tgl_o    = tgl_q;
        ld_ok_o  = res_n_i & wr_stb_i & (state_q != ST_PROG);
    end

    // R3
    strobe_to_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY && wr_stb_i && res_n_i) |=> pull_o);
    // R4
    prog_end_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG && !busy_i && res_n_i) |=> !pull_o);
    // R8
    pin_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_n_i |=> !pull_o);
    // R6
    toggle_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY && wr_stb_i && res_n_i) |=> tgl_o);
    // R6
    toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o && !rd_done_i && !wr_stb_i) |=> $stable(tgl_o));
endmodule

// File: rtl/psr_lane.sv
module psr_lane #(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en_i,
    input  logic [LANE_W-1:0] ld_byte_i,
    input  logic [LANE_W-1:0] arr_byte_i,
    input  logic              status_i,
    input  logic              tgl_i,
    input  logic              oe_i,
    output logic [LANE_W-1:0] out_o
);
    localparam int POLL_BIT = LANE_W - 1;
    localparam int TGL_BIT  = LANE_W - 2;

    logic [LANE_W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       held_q <= '0;
        else if (ld_en_i) held_q <= ld_byte_i;
    end

    always_comb begin
        out_o = '0;
        if (oe_i) begin
            if (status_i) begin
                out_o           = held_q;
                out_o[POLL_BIT] = ~held_q[POLL_BIT];
                out_o[TGL_BIT]  = tgl_i;
            end else begin
                out_o = arr_byte_i;
            end
        end
    end
endmodule

// File: rtl/prog_status_rpt.sv
module prog_status_rpt #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     res_n_i,
    input  logic                     busy_i,
    input  logic                     wr_stb_i,
    input  logic [DATA_W/LANE_W-1:0] wr_be_i,
    input  logic [DATA_W-1:0]        wr_data_i,
    input  logic                     ce_n_i,
    input  logic                     oe_n_i,
    input  logic                     we_n_i,
    input  logic [DATA_W-1:0]        array_data_i,
    output logic [DATA_W-1:0]        rd_data_o,
    output logic                     rd_oe_o,
    output logic                     rdy_pull_o
);
    localparam int LANES = DATA_W / LANE_W;

    logic rd_act, rd_done, status, tgl, ld_ok;

    psr_read_detect u_rdet (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_n_i   (res_n_i),
        .ce_n_i    (ce_n_i),
        .oe_n_i    (oe_n_i),
        .we_n_i    (we_n_i),
        .rd_act_o  (rd_act),
        .rd_done_o (rd_done)
    );

    psr_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_n_i   (res_n_i),
        .busy_i    (busy_i),
        .wr_stb_i  (wr_stb_i),
        .rd_done_i (rd_done),
        .status_o  (status),
        .tgl_o     (tgl),
        .pull_o    (rdy_pull_o),
        .ld_ok_o   (ld_ok)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        psr_lane #(.LANE_W(LANE_W)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .ld_en_i    (ld_ok & wr_be_i[k]),
            .ld_byte_i  (wr_data_i[k*LANE_W +: LANE_W]),
            .arr_byte_i (array_data_i[k*LANE_W +: LANE_W]),
            .status_i   (status),
            .tgl_i      (tgl),
            .oe_i       (rd_act),
            .out_o      (rd_data_o[k*LANE_W +: LANE_W])
        );
    end

    assign rd_oe_o = rd_act;

    // R2
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n_i || oe_n_i || !we_n_i || !res_n_i) |-> (!rd_oe_o && rd_data_o == '0));
    // R1
    idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_pull_o && rd_oe_o) |-> (rd_data_o == array_data_i));
endmodule

// File: tb/prog_status_rpt_tb_top.sv
module prog_status_rpt_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic res_n = 1'b1, busy = 1'b0, wr_stb = 1'b0;
    logic [3:0] wr_be = '0;
    logic [31:0] wr_data = '0, arr = '0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [31:0] rd_data;
    logic rd_oe, rdy_pull;

    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    prog_status_rpt dut_i (
        .clk(clk), .rst_n(rst_n), .res_n_i(res_n), .busy_i(busy),
        .wr_stb_i(wr_stb), .wr_be_i(wr_be), .wr_data_i(wr_data),
        .ce_n_i(ce_n), .oe_n_i(oe_n), .we_n_i(we_n), .array_data_i(arr),
        .rd_data_o(rd_data), .rd_oe_o(rd_oe), .rdy_pull_o(rdy_pull)
    );

    // reference model: 0 ready, 1 load, 2 program
    int m_st = 0;
    logic m_tgl = 1'b1, m_prev = 1'b0;
    logic [7:0] m_byte [4];

    function automatic logic m_rd();
        return !ce_n && !oe_n && we_n && res_n;
    endfunction

    function automatic logic [31:0] exp_data();
        logic [31:0] v = '0;
        if (!m_rd()) return '0;
        if (m_st == 0) return arr;
        for (int k = 0; k < 4; k++) begin
            v[k*8 +: 8] = m_byte[k];
            v[k*8 + 7]  = ~m_byte[k][7];
            v[k*8 + 6]  = m_tgl;
        end
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st <= 0; m_tgl <= 1'b1; m_prev <= 1'b0;
            for (int k = 0; k < 4; k++) m_byte[k] <= '0;
        end else begin
            m_prev <= m_rd();
            if (res_n && wr_stb && m_st != 2)
                for (int k = 0; k < 4; k++)
                    if (wr_be[k]) m_byte[k] <= wr_data[k*8 +: 8];
            if (res_n && m_st == 0 && wr_stb) m_tgl <= 1'b1;
            else if (m_st != 0 && m_prev && !m_rd()) m_tgl <= ~m_tgl;
            if (!res_n) m_st <= 0;
            else case (m_st)
                0: if (wr_stb) m_st <= 1;
                1: if (busy)   m_st <= 2;
                default: if (!busy) m_st <= 0;
            endcase
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [31:0] e = exp_data();
        chk(rd_oe === m_rd(), "R2 R8 bus enable", {31'b0, rd_oe}, {31'b0, m_rd()});
        chk(rdy_pull === (m_st != 0), "R3 R4 R8 busy pull", {31'b0, rdy_pull}, {31'b0, m_st != 0});
        chk(rd_data === e, (m_st == 0) ? "R1 R7 read data" : "R5 R6 status data", rd_data, e);
    endtask

    task automatic step();
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        repeat (3) @(negedge clk);
        #1;
        chk(rd_oe === 1'b0 && rdy_pull === 1'b0, "R2 R3 reset state", {30'b0, rd_oe, rdy_pull}, 32'h0);
        rst_n = 1'b1;
        // R1 idle pass-through
        step(); arr = 32'hA5A5_5A5A; ce_n = 0; oe_n = 0; #1; compare_all();
        chk(rd_data === 32'hA5A5_5A5A, "R1 idle read", rd_data, 32'hA5A5_5A5A);
        // R2 write enable low blocks read
        step(); we_n = 0; #1; chk(rd_oe === 1'b0 && rd_data === 0, "R2 we low", rd_data, 0);
        step(); we_n = 1; ce_n = 1; #1; compare_all();
        // R3 load start, lanes 0 and 2
        step(); wr_stb = 1; wr_be = 4'b0101; wr_data = 32'h12B4_56F8; #1; compare_all();
        step(); #1; chk(rdy_pull === 1'b1, "R3 pull after strobe", {31'b0, rdy_pull}, 1);
        // R5 R6 first status read
        step(); ce_n = 0; oe_n = 0; #1; compare_all();
        chk({rd_data[31], rd_data[23], rd_data[15], rd_data[7]} === 4'b1010, "R5 poll bits",
            {28'b0, rd_data[31], rd_data[23], rd_data[15], rd_data[7]}, 32'hA);
        chk(rd_data[6] === 1'b1, "R6 first toggle is 1", {31'b0, rd_data[6]}, 1);
        repeat (3) begin step(); #1; compare_all(); end
        chk(rd_data[6] === 1'b1, "R6 long read no toggle", {31'b0, rd_data[6]}, 1);
        step(); oe_n = 1; #1; compare_all();
        step(); oe_n = 0; #1; compare_all();
        chk(rd_data[6] === 1'b0, "R6 second read toggles", {31'b0, rd_data[6]}, 0);
        // R4 program then end
        step(); busy = 1; #1; compare_all();
        step(); #1; compare_all();
        step(); busy = 0; #1; compare_all();
        step(); #1; chk(rdy_pull === 1'b0, "R4 pull released", {31'b0, rdy_pull}, 0);
        compare_all();
        chk(rd_data === arr, "R7 array after done", rd_data, arr);
        // R7 toggle restarts
        step(); oe_n = 1; wr_stb = 1; wr_be = 4'b1111; wr_data = 32'h0102_0304; #1; compare_all();
        step(); oe_n = 0; #1; compare_all();
        chk(rd_data[6] === 1'b1, "R7 toggle restarts", {31'b0, rd_data[6]}, 1);
        // R8 reset pin
        step(); res_n = 0; #1; compare_all();
        chk(rd_oe === 1'b0 && rd_data === 0, "R8 float on reset pin", rd_data, 0);
        step(); wr_stb = 1; #1; chk(rdy_pull === 1'b0, "R8 pull released", {31'b0, rdy_pull}, 0);
        step(); #1; chk(rdy_pull === 1'b0, "R8 strobe ignored", {31'b0, rdy_pull}, 0);
        compare_all();
        step(); res_n = 1; #1; compare_all();
        // constrained random
        seed = $urandom(32'h5EED_0042);
        for (int i = 0; i < 6000; i++) begin
            step();
            arr = $urandom;
            wr_data = $urandom;
            wr_be = 4'($urandom);
            wr_stb = ($urandom % 100) < 8;
            if (($urandom % 100) < 30) ce_n = ~ce_n;
            if (($urandom % 100) < 30) oe_n = ~oe_n;
            we_n = ($urandom % 100) >= 10;
            if (res_n) res_n = ($urandom % 100) >= 1;
            else       res_n = ($urandom % 100) < 40;
            if (m_st == 1 && ($urandom % 100) < 25) busy = 1;
            else if (m_st == 2 && ($urandom % 100) < 6) busy = 0;
            else if (m_st == 0) busy = 0;
            #1; compare_all();
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule